// File: doc/BRIEF.md
# GPIO Port with Change Alert

This block is a small general-purpose I/O port with three pins, reached through a byte-wide register bus with an address, a data path and a single-cycle strobe. Software sets the pins' output levels through an output data register and chooses which pins may raise an alert through an enable register. A status register records which pins have changed level.

Each pin works in one of four modes, set by a static mode input: disabled, input, push-pull output or open-drain output. The pin inputs are synchronised to the block clock, and any change of level sets a sticky status bit. That bit stays set until software reads the status register. An active-low alert line goes low while a pin in input mode has its status bit and its enable bit both set. The block leaves the pad electronics outside and gives only a level and a drive enable for each pin.

Top module: `chg_alert_gpio`

## Requirements
- R1: After reset, all three registers read 00h, `alert_n` is 1 and every `pin_oe` bit is 0.
- R2: A pin in push-pull mode (mode code 2'b10) has `pin_oe` = 1 and `pin_out` equal to its output data bit, starting in the cycle after the write.
- R3: A pin in open-drain mode (mode code 2'b11) always has `pin_out` = 0. An output data bit of 0 gives `pin_oe` = 1, and a bit of 1 gives `pin_oe` = 0, which releases the pin.
- R4: Any rise or fall on a pin input sets that pin's status bit within three clock cycles. This happens whatever the enable bit or the pin mode. Once set, the bit stays set until the status register is read.
- R5: A read of the status register returns the bits held before the read and then clears them. If a new change is detected in the same cycle as the read, that pin's bit stays set.
- R6: `alert_n` is 0 exactly when some pin in input mode (mode code 2'b01) has both its status bit and its enable bit at 1. It returns to 1 once the status read clears those bits.
- R7: An enable bit has no effect on `alert_n` when it is 0, or when its pin is disabled or set as an output. The status bit is still set in those cases.
- R8: Register map: output data at E4h, enable at E5h, status at E6h. Bit 0 belongs to pin 1, bit 1 to pin 2 and bit 2 to pin 3. Bits 7 to 3 read 0 and ignore writes. The status register ignores writes, and other addresses read 00h.
- R9: A pin that is disabled (2'b00) or in input mode (2'b01) has `pin_oe` = 0 and `pin_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while the strobe is high |
| pin_mode | input | 6 | Two bits per pin: 00 off, 01 input, 10 push-pull, 11 open-drain |
| pin_in | input | 3 | Pin levels from the pads, asynchronous |
| pin_out | output | 3 | Level to drive on each pin |
| pin_oe | output | 3 | Drive enable for each pin |
| alert_n | output | 1 | Active-low change alert |

## Verification
The change detector is tested with rising and falling edges on single pins, with repeated toggles before a read, and with a change that arrives in the same cycle as a status read. Together these show that detection works on both edges, that the bit is sticky, and that the clear does not lose an event. The alert is tested in four cases: masked, enabled on an input pin, enabled on a pin in push-pull mode, and enabled only on a pin other than the one that changed. These cases separate correct alert gating from gating that looks only at the status bit. The drive logic is tested with the same data pattern under all four modes, which tells the push-pull, open-drain and released behaviours apart.

// File: rtl/gpa_pkg.sv
package gpa_pkg;
   typedef enum logic [1:0] {
      PM_OFF = 2'b00,
      PM_IN  = 2'b01,
      PM_PP  = 2'b10,
      PM_OD  = 2'b11
   } pin_mode_e;
endpackage

// File: rtl/gpa_sync_edge.sv
module gpa_sync_edge #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] sync_out,
   output logic [W-1:0] chg
);
   initial begin
      if (STAGES < 2) $error("gpa_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] stage_q;
   logic [W-1:0]             prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         prev_q  <= '0;
      end else begin
         stage_q[0] <= async_in;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
         prev_q <= stage_q[STAGES-1];
      end
   end

   assign sync_out = stage_q[STAGES-1];
   assign chg      = stage_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/gpa_pad_drive.sv
module gpa_pad_drive
   import gpa_pkg::*;
(
   input  logic [1:0] mode,
   input  logic       data,
   output logic       drv_level,
   output logic       drv_en,
   output logic       is_input
);
   always_comb begin
      drv_level = 1'b0;
      drv_en    = 1'b0;
      is_input  = 1'b0;
      case (pin_mode_e'(mode))
         PM_IN: is_input = 1'b1;
         PM_PP: begin
            drv_en    = 1'b1;
            drv_level = data;
         end
         PM_OD: drv_en = ~data;
         default: ;
      endcase
   end
endmodule

// File: rtl/gpa_status.sv
module gpa_status #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] chg,
   output logic [W-1:0] sts
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts <= '0;
      else        sts <= (clr ? '0 : sts) | chg;
   end
endmodule

// File: rtl/chg_alert_gpio.sv
module chg_alert_gpio #(
   parameter int          NUM_PINS    = 3,
   parameter int          ADDR_W      = 8,
   parameter int          DATA_W      = 8,
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  ADDR_OUT    = 8'hE4,
   parameter logic [7:0]  ADDR_EN     = 8'hE5,
   parameter logic [7:0]  ADDR_STS    = 8'hE6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel,
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic [2*NUM_PINS-1:0] pin_mode,
   input  logic [NUM_PINS-1:0]   pin_in,
   output logic [NUM_PINS-1:0]   pin_out,
   output logic [NUM_PINS-1:0]   pin_oe,
   output logic                  alert_n
);
   localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(ADDR_OUT);
   localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(ADDR_EN);
   localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(ADDR_STS);

   initial begin
      if (NUM_PINS < 1 || NUM_PINS > DATA_W)
         $error("chg_alert_gpio: NUM_PINS must lie in 1..DATA_W");
      if (ADDR_W < 8) $error("chg_alert_gpio: ADDR_W must be at least 8");
   end

   logic [NUM_PINS-1:0] out_q, en_q, sts_q, chg, in_sync, in_mode;
   logic                wr_out, wr_en, rd_sts;
   logic                unused_wdata;

   assign unused_wdata = &{1'b0, bus_wdata, in_sync};

   assign wr_out = bus_sel &  bus_wr & (bus_addr == A_OUT);
   assign wr_en  = bus_sel &  bus_wr & (bus_addr == A_EN);
   assign rd_sts = bus_sel & ~bus_wr & (bus_addr == A_STS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         en_q  <= '0;
      end else begin
         if (wr_out) out_q <= bus_wdata[NUM_PINS-1:0];
         if (wr_en)  en_q  <= bus_wdata[NUM_PINS-1:0];
      end
   end

   gpa_sync_edge #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .async_in(pin_in),
      .sync_out(in_sync), .chg(chg)
   );

   gpa_status #(.W(NUM_PINS)) sts_i (
      .clk(clk), .rst_n(rst_n), .clr(rd_sts), .chg(chg), .sts(sts_q)
   );

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      gpa_pad_drive drv_i (
         .mode(pin_mode[2*p +: 2]), .data(out_q[p]),
         .drv_level(pin_out[p]), .drv_en(pin_oe[p]), .is_input(in_mode[p])
      );
   end

   assign alert_n = ~|(sts_q & en_q & in_mode);

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         if (bus_addr == A_OUT)      bus_rdata[NUM_PINS-1:0] = out_q;
         else if (bus_addr == A_EN)  bus_rdata[NUM_PINS-1:0] = en_q;
         else if (bus_addr == A_STS) bus_rdata[NUM_PINS-1:0] = sts_q;
      end
   end
endmodule

// File: rtl/gpa_checker.sv
module gpa_checker #(
   parameter int NUM_PINS = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  rd_sts,
   input logic [2*NUM_PINS-1:0] pin_mode,
   input logic [NUM_PINS-1:0]   pin_out,
   input logic [NUM_PINS-1:0]   pin_oe,
   input logic [NUM_PINS-1:0]   out_data,
   input logic [NUM_PINS-1:0]   en,
   input logic [NUM_PINS-1:0]   sts,
   input logic [NUM_PINS-1:0]   chg,
   input logic                  alert_n
);
   // R4: set status bits stay set unless the status register is read
   a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_sts |=> ((sts & $past(sts)) == $past(sts)));

   // R5: a read with no coincident change leaves status clear
   a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sts && chg == '0) |=> (sts == '0));

   // R7: with every enable at 0 the alert stays released
   a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> alert_n);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
      // R2: push-pull drives the stored data bit
      a_r2_pp_drive: assert property (@(posedge clk) disable iff (!rst_n)
         (pin_mode[2*p +: 2] == 2'b10) |-> (pin_oe[p] && pin_out[p] == out_data[p]));
      // R3: open-drain never drives high
      a_r3_od_low: assert property (@(posedge clk) disable iff (!rst_n)
         (pin_mode[2*p +: 2] == 2'b11) |-> (!pin_out[p] && pin_oe[p] == !out_data[p]));
      // R9: disabled or input pins are not driven
      a_r9_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
         (pin_mode[2*p+1] == 1'b0) |-> (!pin_oe[p] && !pin_out[p]));
   end
endmodule

bind chg_alert_gpio gpa_checker #(.NUM_PINS(NUM_PINS)) chk_i (
   .clk(clk), .rst_n(rst_n), .rd_sts(rd_sts), .pin_mode(pin_mode),
   .pin_out(pin_out), .pin_oe(pin_oe), .out_data(out_q), .en(en_q),
   .sts(sts_q), .chg(chg), .alert_n(alert_n)
);

// File: tb/chg_alert_gpio_tb_top.sv
module chg_alert_gpio_tb_top;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0;
   logic [7:0] bus_addr = '0, bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [5:0] pin_mode = '0;
   logic [2:0] pin_in = '0;
   logic [2:0] pin_out, pin_oe;
   logic       alert_n;

   int errors = 0, checks = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   chg_alert_gpio dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_mode(pin_mode), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .alert_n(alert_n)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); #1;
      bus_sel = 1'b0;
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      @(negedge clk);
      check("R1 alert_n", alert_n, 1);
      check("R1 pin_oe", pin_oe, 0);
      bus_read(8'hE4, d); check("R1 out reg", d, 8'h00);
      bus_read(8'hE5, d); check("R1 en reg", d, 8'h00);
      bus_read(8'hE6, d); check("R1 sts reg", d, 8'h00);
   endtask

   task automatic t_regmap();
      logic [7:0] d;
      bus_write(8'hE4, 8'hFF); bus_read(8'hE4, d); check("R8 out upper bits", d, 8'h07);
      bus_write(8'hE5, 8'hFA); bus_read(8'hE5, d); check("R8 en upper bits", d, 8'h02);
      bus_write(8'hE6, 8'hFF); bus_read(8'hE6, d); check("R8 sts ignores write", d, 8'h00);
      bus_read(8'hE7, d); check("R8 unmapped read", d, 8'h00);
      bus_write(8'hE5, 8'h00);
   endtask

   task automatic t_drive();
      bus_write(8'hE4, 8'h05);
      pin_mode = 6'b10_10_10; @(negedge clk);
      check("R2 pp oe", pin_oe, 3'b111);
      check("R2 pp out", pin_out, 3'b101);
      pin_mode = 6'b11_11_11; @(negedge clk);
      check("R3 od oe", pin_oe, 3'b010);
      check("R3 od out", pin_out, 3'b000);
      pin_mode = 6'b01_00_01; @(negedge clk);
      check("R9 off/in oe", pin_oe, 3'b000);
      check("R9 off/in out", pin_out, 3'b000);
      bus_write(8'hE4, 8'h02);
      pin_mode = 6'b10_10_10; @(negedge clk);
      check("R2 pp follows new data", pin_out, 3'b010);
   endtask

   task automatic t_masked_and_sticky();
      logic [7:0] d;
      pin_mode = 6'b01_01_01;
      bus_write(8'hE5, 8'h00);
      bus_read(8'hE6, d);
      pin_in[0] = 1'b1; wait_clk(4);
      check("R7 masked alert", alert_n, 1);
      pin_in[0] = 1'b0; wait_clk(4);
      bus_read(8'hE6, d); check("R4 sticky after two edges", d, 8'h01);
      bus_read(8'hE6, d); check("R5 cleared by read", d, 8'h00);
   endtask

   task automatic t_alert();
      logic [7:0] d;
      bus_write(8'hE5, 8'h01);
      pin_in[0] = 1'b1; wait_clk(4);
      check("R6 alert on enabled input", alert_n, 0);
      pin_in[1] = 1'b1; wait_clk(4);
      bus_read(8'hE6, d); check("R4 two pins set", d, 8'h03);
      @(negedge clk); check("R6 alert released after read", alert_n, 1);
      pin_in[1] = 1'b0; wait_clk(4);
      check("R6 other pin not enabled", alert_n, 1);
      bus_read(8'hE6, d); check("R4 falling edge pin2", d, 8'h02);
   endtask

   task automatic t_enable_ignored();
      logic [7:0] d;
      pin_mode = 6'b10_01_01;
      bus_write(8'hE5, 8'h04);
      pin_in[2] = 1'b1; wait_clk(4);
      check("R7 enable ignored for output pin", alert_n, 1);
      bus_read(8'hE6, d); check("R7 status still set", d, 8'h04);
      pin_mode = 6'b00_01_01;
      pin_in[2] = 1'b0; wait_clk(4);
      check("R7 enable ignored for disabled pin", alert_n, 1);
      bus_read(8'hE6, d);
      bus_write(8'hE5, 8'h00);
   endtask

   task automatic t_coincident();
      logic [7:0] d;
      pin_mode = 6'b01_01_01;
      bus_read(8'hE6, d);
      @(negedge clk); pin_in[1] = 1'b1;
      @(posedge clk); @(posedge clk);
      bus_read(8'hE6, d); check("R5 read value before clear", d, 8'h00);
      bus_read(8'hE6, d); check("R5 coincident change kept", d, 8'h02);
   endtask

   initial begin
      #(CLK_P*20000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_regmap();
      t_drive();
      t_masked_and_sticky();
      t_alert();
      t_enable_ignored();
      t_coincident();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule